// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core that retires one instruction on every clock edge. It fetches a word from an internal instruction store, decodes it into a fixed set of steering bits, reads two operands from a 32-entry register file, computes a sum or difference, optionally touches an internal data store, and commits the register write, the store and the new program counter together on the next rising edge. Six instructions are recognised: register add, add-immediate, word load, word store, branch-if-equal and absolute jump. Every other encoding advances the program counter and changes nothing else.

Both internal stores hold 256 words and are indexed by address bits [9:2]. They are filled through one shared load port that takes effect only while the synchronous active-low reset is held. The core exposes its program counter, its register-write bus and its store bus so that surrounding logic can trace each retired instruction.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the program counter, all registers and the outputs `rf_we_o` and `dm_we_o` are held at 0; the first instruction after release is fetched from address 0.
- R2: An instruction that is not a taken branch or a jump advances the program counter by 4 at the next edge.
- R3: Opcode 0x00 with function field [5:0] = 0x20 writes rs[25:21] + rt[20:16] into rd[15:11].
- R4: Opcode 0x08 writes rs plus the sign-extended immediate [15:0] into rt.
- R5: Opcode 0x23 writes into rt the data word at address rs + sign-extended immediate, using address bits [9:2].
- R6: Opcode 0x2B stores register rt at address rs + sign-extended immediate (bits [9:2] select the word) and makes no register write.
- R7: Opcode 0x04 sets the next program counter to PC+4 + (sign-extended immediate << 2) when rs equals rt, and to PC+4 otherwise; it writes nothing.
- R8: Opcode 0x02 sets the next program counter to {PC+4 [31:28], instruction[25:0], 2'b00}; it writes nothing.
- R9: Register 0 always reads as 0; a write addressed to it leaves it 0.
- R10: Any other opcode, and opcode 0x00 with a function field other than 0x20, makes no register write and no store and only advances the program counter by 4.
- R11: The load port (`ld_imem_we`, `ld_dmem_we`, `ld_addr`, `ld_data`) writes the selected store only while `rst_n` is low; with `rst_n` high it has no effect on fetched instructions or loaded data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also enables the load port |
| ld_imem_we | input | 1 | Load-port write enable for the instruction store |
| ld_dmem_we | input | 1 | Load-port write enable for the data store |
| ld_addr | input | 8 | Word index for the load port |
| ld_data | input | 32 | Word written through the load port |
| pc_o | output | 32 | Address of the instruction now executing |
| rf_we_o | output | 1 | Register write happens at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |
| dm_we_o | output | 1 | Store happens at the next edge |
| dm_addr_o | output | 32 | Byte address of the store or load |
| dm_wdata_o | output | 32 | Value being stored |

## Verification
The assertions check on every cycle that reset pins the program counter to zero, that a store never coincides with a register write, that register 0 reads zero on both ports, that unrecognised encodings produce no writes, and that non-control-flow instructions step the counter by four and jumps land on the formed target. Whether the values written are correct (sums, loaded words, branch decisions that depend on earlier writes, and the load port being ignored after reset) can only be shown by the bench's programs, which run the core against an independent instruction-level model over a directed sequence and a long random one.

// File: rtl/sc_pkg.sv
// Shared encodings and the control word for the single-cycle core.
// Assumes the classic 6-bit opcode in [31:26] and 6-bit function in [5:0].
package sc_pkg;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] FN_ADD    = 6'h20;

    // Eight steering bits produced per opcode.
    typedef struct packed {
        logic br_en;       // branch on equal
        logic jmp_en;      // absolute jump
        logic use_imm;     // second operand is the immediate
        logic sub_op;      // subtract instead of add
        logic mem_wr;      // store to data store
        logic reg_wr;      // register file write
        logic dst_rd;      // destination is rd (else rt)
        logic wb_mem;      // write-back from data store (else ALU)
    } ctl_t;

endpackage

// File: rtl/sc_ctrl.sv
// Control decoder: maps opcode and function field to the steering word.
// Purely combinational; unknown encodings yield an all-zero word (no-op).
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl
);

    // Per-opcode table of steering bits.
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_REG: begin
                if (funct == FN_ADD) begin
                    ctl.reg_wr = 1'b1;
                    ctl.dst_rd = 1'b1;
                end
            end
            OPC_ADDI: begin
                ctl.use_imm = 1'b1;
                ctl.reg_wr  = 1'b1;
            end
            OPC_LOAD: begin
                ctl.use_imm = 1'b1;
                ctl.reg_wr  = 1'b1;
                ctl.wb_mem  = 1'b1;
            end
            OPC_STORE: begin
                ctl.use_imm = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.sub_op = 1'b1;
                ctl.br_en  = 1'b1;
            end
            OPC_JUMP: ctl.jmp_en = 1'b1;
            default:  ctl = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
// Register file: NREG x XLEN, two combinational read ports, one write port.
// Entry 0 is never written and reads zero. Synchronous active-low clear.
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREG];

    // Entry 0 is a constant zero.
    assign regs[0] = '0;

    // Clear on reset, else write the addressed entry.
    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && wa == RAW'(g))
                regs[g] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    a_r9_zero_port1: assert property (@(posedge clk) (ra1 == '0) |-> (rd1 == '0));
    a_r9_zero_port2: assert property (@(posedge clk) (ra2 == '0) |-> (rd2 == '0));

endmodule

// File: rtl/sc_wmem.sv
// Word store: DEPTH words of W bits, one synchronous write port and one
// combinational read port. Addresses are word indices.
module sc_wmem #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Write the addressed word.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: fetch, decode, operand read, add/subtract,
// data access and commit of PC, register and store in one clock.
// Assumes the stores are filled through the load port while rst_n is low.
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MEM_AW = 8,
    localparam int NREG  = 32,
    localparam int RAW   = $clog2(NREG),
    localparam int DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_imem_we,
    input  logic              ld_dmem_we,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              rf_we_o,
    output logic [RAW-1:0]    rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              dm_we_o,
    output logic [XLEN-1:0]   dm_addr_o,
    output logic [XLEN-1:0]   dm_wdata_o
);

    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [XLEN-1:0]   instr, imm_sx, opa, opr, opb, alu_res, dm_rdata;
    logic [RAW-1:0]    rs_idx, rt_idx, rd_idx;
    logic              take_br;
    ctl_t              ctl;
    logic              dm_we_int;
    logic [MEM_AW-1:0] dm_waddr_int;
    logic [XLEN-1:0]   dm_wdata_int;

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    sc_wmem #(.W(XLEN), .DEPTH(DEPTH)) imem_i (
        .clk   (clk),
        .we    (ld_imem_we && !rst_n),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (pc_q[MEM_AW+1:2]),
        .rdata (instr)
    );

    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_ctrl ctrl_i (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rs_idx),
        .ra2   (rt_idx),
        .rd1   (opa),
        .rd2   (opr),
        .we    (rf_we_o),
        .wa    (rf_waddr_o),
        .wd    (rf_wdata_o)
    );

    // Second operand select and add/subtract.
    always_comb begin
        opb     = ctl.use_imm ? imm_sx : opr;
        alu_res = ctl.sub_op ? (opa - opb) : (opa + opb);
    end

    // Next-PC formation: sequential, branch target or jump target.
    always_comb begin
        pc_plus4 = pc_q + XLEN'(4);
        br_tgt   = pc_plus4 + (imm_sx << 2);
        jmp_tgt  = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
        take_br  = ctl.br_en && (alu_res == '0);
        if (ctl.jmp_en)
            pc_next = jmp_tgt;
        else if (take_br)
            pc_next = br_tgt;
        else
            pc_next = pc_plus4;
    end

    // Data store write port: loader during reset, core afterwards.
    always_comb begin
        if (!rst_n) begin
            dm_we_int    = ld_dmem_we;
            dm_waddr_int = ld_addr;
            dm_wdata_int = ld_data;
        end else begin
            dm_we_int    = ctl.mem_wr;
            dm_waddr_int = alu_res[MEM_AW+1:2];
            dm_wdata_int = opr;
        end
    end

    sc_wmem #(.W(XLEN), .DEPTH(DEPTH)) dmem_i (
        .clk   (clk),
        .we    (dm_we_int),
        .waddr (dm_waddr_int),
        .wdata (dm_wdata_int),
        .raddr (alu_res[MEM_AW+1:2]),
        .rdata (dm_rdata)
    );

    // Trace outputs and write-back select.
    always_comb begin
        pc_o       = pc_q;
        rf_we_o    = ctl.reg_wr && rst_n;
        rf_waddr_o = ctl.dst_rd ? rd_idx : rt_idx;
        rf_wdata_o = ctl.wb_mem ? dm_rdata : alu_res;
        dm_we_o    = ctl.mem_wr && rst_n;
        dm_addr_o  = alu_res;
        dm_wdata_o = opr;
    end

    a_r1_reset_pc: assert property (@(posedge clk) !rst_n |=> (pc_q == '0));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.jmp_en && !take_br) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    a_r6_store_no_regwr: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> !rf_we_o);

    a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jmp_en |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

    a_r10_unknown_nop: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr[31:26] != OPC_REG) && (instr[31:26] != OPC_ADDI) &&
         (instr[31:26] != OPC_LOAD) && (instr[31:26] != OPC_STORE) &&
         (instr[31:26] != OPC_BEQ) && (instr[31:26] != OPC_JUMP))
        |-> (!rf_we_o && !dm_we_o));

endmodule

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
// Bench: loads programs during reset, then runs the core against an
// instruction-level model and compares the trace outputs every cycle.
module sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o;
    logic [4:0]  rf_waddr_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_im [256];
    logic [31:0] m_dm [256];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;
    string       pc_req;

    always #10 clk = ~clk;

    sc_core dut_i (
        .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
        .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'h02, tgt};
    endfunction
    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Hold reset, fill both stores, check the reset state (R1).
    task automatic load_and_reset();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            ld_imem_we = 1'b1; ld_dmem_we = 1'b0; ld_addr = 8'(i); ld_data = m_im[i];
            @(negedge clk);
        end
        for (int i = 0; i < 256; i++) begin
            ld_imem_we = 1'b0; ld_dmem_we = 1'b1; ld_addr = 8'(i); ld_data = m_dm[i];
            @(negedge clk);
        end
        ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
        #1;
        chk("R1 pc in reset", pc_o, 32'h0);
        chk("R1 rf_we in reset", {31'd0, rf_we_o}, 32'h0);
        chk("R1 dm_we in reset", {31'd0, dm_we_o}, 32'h0);
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_pc = '0;
        pc_req = "R1";
        @(negedge clk);
        // From here on the load port is driven with junk (R11).
        ld_imem_we = 1'b1; ld_dmem_we = 1'b1; ld_addr = 8'd7; ld_data = 32'hDEAD_BEEF;
        rst_n = 1'b1;
        #1;
    endtask

    // Compare one executing instruction, then advance the model.
    task automatic step_check();
        logic [31:0] ins, a, b, ea, nxt;
        logic [5:0]  op;
        logic        e_rwe, e_dwe;
        logic [4:0]  e_wa;
        logic [31:0] e_wd;
        string       lbl;
        ins = m_im[m_pc[9:2]];
        op  = ins[31:26];
        a   = m_rf[ins[25:21]];
        b   = m_rf[ins[20:16]];
        ea  = a + sx(ins[15:0]);
        nxt = m_pc + 4;
        e_rwe = 1'b0; e_dwe = 1'b0; e_wa = '0; e_wd = '0;
        lbl = "R10";
        chk({pc_req, " pc"}, pc_o, m_pc);
        if (op == 6'h00 && ins[5:0] == 6'h20) begin
            lbl = "R3"; e_rwe = 1'b1; e_wa = ins[15:11]; e_wd = a + b;
        end else if (op == 6'h08) begin
            lbl = "R4"; e_rwe = 1'b1; e_wa = ins[20:16]; e_wd = ea;
        end else if (op == 6'h23) begin
            lbl = "R5 R11"; e_rwe = 1'b1; e_wa = ins[20:16]; e_wd = m_dm[ea[9:2]];
        end else if (op == 6'h2B) begin
            lbl = (ins[20:16] == 5'd0) ? "R6 R9" : "R6"; e_dwe = 1'b1;
        end else if (op == 6'h04) begin
            lbl = "R7";
            if (a == b) nxt = m_pc + 4 + (sx(ins[15:0]) << 2);
        end else if (op == 6'h02) begin
            lbl = "R8"; nxt = {nxt[31:28], ins[25:0], 2'b00};
        end
        if (e_rwe && e_wa == 5'd0) lbl = {lbl, " R9"};
        chk({lbl, " rf_we"}, {31'd0, rf_we_o}, {31'd0, e_rwe});
        if (e_rwe) begin
            chk({lbl, " rf_waddr"}, {27'd0, rf_waddr_o}, {27'd0, e_wa});
            chk({lbl, " rf_wdata"}, rf_wdata_o, e_wd);
        end
        chk({lbl, " dm_we"}, {31'd0, dm_we_o}, {31'd0, e_dwe});
        if (e_dwe) begin
            chk({lbl, " dm_addr"}, dm_addr_o, ea);
            chk({lbl, " dm_wdata"}, dm_wdata_o, b);
        end
        if (e_rwe && e_wa != 5'd0) m_rf[e_wa] = e_wd;
        if (e_dwe) m_dm[ea[9:2]] = b;
        m_pc   = nxt;
        pc_req = (lbl == "R10" || lbl == "R3" || lbl == "R4" || lbl == "R5 R11") ? "R2" : lbl;
        @(negedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200_000 * 20);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Directed program.
        for (int i = 0; i < 256; i++) begin m_im[i] = enc_r(0, 0, 0, 6'h20); m_dm[i] = 32'h1000 + 32'(i); end
        m_dm[7]  = 32'hCAFE_F00D;
        m_im[0]  = enc_i(6'h08, 0, 1, 16'd7);          // r1 = 7
        m_im[1]  = enc_i(6'h08, 0, 2, 16'hFFFD);       // r2 = -3
        m_im[2]  = enc_r(1, 2, 3, 6'h20);              // r3 = 4
        m_im[3]  = enc_i(6'h2B, 0, 3, 16'd8);          // store r3 -> word 2
        m_im[4]  = enc_i(6'h23, 0, 4, 16'd8);          // r4 = word 2
        m_im[5]  = enc_i(6'h23, 0, 5, 16'd28);         // r5 = word 7 (load port busy)
        m_im[6]  = enc_i(6'h04, 1, 2, 16'd5);          // not taken
        m_im[7]  = enc_i(6'h04, 3, 4, 16'd1);          // taken to 9
        m_im[8]  = enc_i(6'h08, 0, 6, 16'd99);         // skipped
        m_im[9]  = enc_i(6'h08, 0, 0, 16'd5);          // write to r0
        m_im[10] = enc_i(6'h2B, 0, 0, 16'd12);         // store r0
        m_im[11] = 32'hFC00_0000;                      // unknown opcode
        m_im[12] = enc_r(1, 2, 7, 6'h22);              // unknown function
        m_im[13] = enc_j(26'd20);
        m_im[20] = enc_i(6'h23, 0, 8, 16'hFFFC);       // negative offset wraps
        m_im[21] = enc_i(6'h04, 0, 0, 16'hFFFF);       // branch to self
        load_and_reset();
        for (int c = 0; c < 30; c++) step_check();

        // Random program with fixed seed.
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            int k;
            int rs, rt, rd;
            rs = int'($urandom % 8); rt = int'($urandom % 8); rd = int'($urandom % 8);
            k  = int'($urandom % 8);
            m_dm[i] = $urandom;
            case (k)
                0, 1: m_im[i] = enc_r(rs, rt, rd, 6'h20);
                2:    m_im[i] = enc_i(6'h08, rs, rt, 16'($signed($urandom % 64) - 32));
                3:    m_im[i] = enc_i(6'h23, rs, rt, 16'($urandom % 1024));
                4:    m_im[i] = enc_i(6'h2B, rs, rt, 16'($urandom % 1024));
                5:    m_im[i] = enc_i(6'h04, rs % 3, rt % 3, 16'($signed($urandom % 17) - 8));
                6:    m_im[i] = enc_j(26'($urandom % 256));
                default: m_im[i] = ($urandom % 2 == 0) ? {6'h3E, 26'($urandom)} : enc_r(rs, rt, rd, 6'h24);
            endcase
        end
        load_and_reset();
        for (int c = 0; c < 3000; c++) step_check();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule